// File: doc/BRIEF.md
# Lookahead FIFO with Registered Capacity Flags

This block is a single-clock, shallow FIFO. Its two sides work differently. On the write side a producer offers one item per cycle, and the FIFO returns registered `full` and `almost_full` flags. Because both flags come from flops, a producer whose own write request also comes from a flop can use every slot and still never overrun the FIFO. On the read side the consumer does not take items one at a time from the head. It sees a window: it picks any stored entry by its distance from the oldest one, reads that entry combinationally, and then releases the oldest entry with `pop`. While a burst is being consumed out of order, new items can keep arriving behind it.

Back-pressure follows one rule set. A write takes effect on a clock edge only while `full` is low, and a write offered while `full` is high is dropped and sets the sticky `overflow` bit. A producer that registers its request must not write in the cycle right after one of its own writes while `almost_full` is high; that one-cycle hold covers the request still in flight. The module `la_seq_producer` follows these rules and streams consecutive values, like an address counter walking a ROM. The bench uses it as its producer.

Top module: `la_fifo`

## Requirements
- R1: While reset is held and after it is released, `count` is 0, `empty` is 1, and `full`, `almost_full` and `overflow` are 0.
- R2: `count` changes only on a clock edge. An accepted write alone adds 1, an accepted pop alone subtracts 1, and both together or neither leave it unchanged.
- R3: `count` never exceeds DEPTH (default 4, with a 3-bit `count`).
- R4: `full` is registered and is high exactly when `count` equals DEPTH. It rises on the edge that stores the last free slot and falls on any edge with a pop and no write.
- R5: `almost_full` is registered and is high exactly when `count` is at least DEPTH-1.
- R6: `la_seq_producer` never presents a write while `full` is high. Its data are 0, 1, 2, … in order, one value for each write. With no pops it fills the FIFO to exactly DEPTH entries and never raises `overflow`.
- R7: `empty` is registered and is high exactly when `count` is 0. A pop while empty is ignored.
- R8: A write while `full` is high is ignored: `count` and the stored entries stay as they were. `overflow` goes to 1 and stays at 1 until reset.
- R9: For any `peek_off` k below `count`, `peek_data` shows the entry that is k places behind the oldest one. It follows `peek_off` combinationally, without waiting for a clock edge.
- R10: Entries leave in write order, with no loss and no duplication, under any pattern of pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | DW | Data to write |
| full | output | 1 | Registered; no free slot |
| almost_full | output | 1 | Registered; at most one free slot |
| empty | output | 1 | Registered; nothing stored |
| count | output | CW | Number of stored entries |
| overflow | output | 1 | Sticky; a write arrived while full |
| pop | input | 1 | Release the oldest entry |
| peek_off | input | AW | Distance from the oldest entry |
| peek_data | output | DW | Entry at `peek_off` |

## Verification
The bench goes after the edges at the top and bottom of the occupancy range.

- Filling to capacity with a registered producer. A design that set `full` one cycle late would accept a fifth item, or would see `count` wrap and `full` drop again.
- Writing and popping together at full. A design that got the set and clear order wrong would keep `full` high after the pop, or would store an item past capacity.
- Popping while empty. A design that did not ignore it would underflow `count` or move the read pointer, so later reads would return stale entries.
- Order checks against a sequential producer under long runs of random pops. These catch pointer wrap errors and lookahead offsets that miss by one as skipped, repeated or out-of-order values.

// File: rtl/la_fifo_pkg.sv
package la_fifo_pkg;

  // How occupancy moves on a given edge.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } occ_step_e;

  // Ring index: base + off, wrapped into 0..depth-1 (base, off < depth).
  function automatic int unsigned ring_idx(int unsigned base,
                                           int unsigned off,
                                           int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/la_fifo_occ.sv
module la_fifo_occ
  import la_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          pop_req,
  output logic          wr_acc,
  output logic          pop_acc,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic          overflow
);

  localparam logic [CW-1:0] LIM_TOP = CW'(DEPTH);
  localparam logic [CW-1:0] LIM_AF  = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  occ_step_e     step;
  logic [CW-1:0] count_nxt;

  assign wr_acc  = wr_req  && !full;
  assign pop_acc = pop_req && !empty;

  always_comb begin
    if (wr_acc && !pop_acc)      step = STEP_INC;
    else if (pop_acc && !wr_acc) step = STEP_DEC;
    else                         step = STEP_HOLD;
  end

  always_comb begin
    unique case (step)
      STEP_INC: count_nxt = count + ONE;
      STEP_DEC: count_nxt = count - ONE;
      default:  count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      empty       <= 1'b1;
      overflow    <= 1'b0;
    end else begin
      count       <= count_nxt;
      almost_full <= (count_nxt >= LIM_AF);
      // full: set while an increment lands at or past the last slot
      if (step == STEP_INC && count >= LIM_AF)
        full <= 1'b1;
      else if (step == STEP_DEC)
        full <= 1'b0;
      // empty: mirror rule at the bottom
      if (step == STEP_DEC && count <= ONE)
        empty <= 1'b1;
      else if (step == STEP_INC)
        empty <= 1'b0;
      if (wr_req && full)
        overflow <= 1'b1;
    end
  end

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM_TOP);
  // R4
  a_r4_full_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    full == (count == LIM_TOP));
  // R5
  a_r5_af_window: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full == (count >= LIM_AF));
  // R7
  a_r7_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0));
  // R7
  a_r7_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_req) |=> (empty && count == '0));
  // R8
  a_r8_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8
  a_r8_full_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !pop_req) |=> (count == LIM_TOP));

endmodule

// File: rtl/la_fifo_store.sv
module la_fifo_store
  import la_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_acc,
  input  logic [AW-1:0] peek_off,
  output logic [DW-1:0] peek_data
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] slot [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW-1:0] peek_idx;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_acc && wptr == AW'(g))
          slot[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_acc)  wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (pop_acc) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
    end
  end

  assign peek_idx  = AW'(ring_idx(int'(rptr), int'(peek_off), DEPTH));
  assign peek_data = slot[peek_idx];

  // R10: the read pointer only moves on an accepted pop
  a_r10_rptr_moves_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_acc |=> $stable(rptr));

endmodule

// File: rtl/la_seq_producer.sv
module la_seq_producer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          full,
  input  logic          almost_full,
  output logic          wr_en,
  output logic [DW-1:0] wr_data
);

  logic [DW-1:0] seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0;
      seq   <= '0;
    end else begin
      // hold one cycle after a write when only one slot may remain
      wr_en <= run && !full && !(wr_en && almost_full);
      if (wr_en) seq <= seq + DW'(1);
    end
  end

  assign wr_data = seq;

  // R6
  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

endmodule

// File: rtl/la_fifo.sv
module la_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          overflow,
  input  logic          pop,
  input  logic [AW-1:0] peek_off,
  output logic [DW-1:0] peek_data
);

  logic wr_acc;
  logic pop_acc;

  la_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_en), .pop_req(pop),
    .wr_acc(wr_acc), .pop_acc(pop_acc),
    .count(count), .full(full), .almost_full(almost_full),
    .empty(empty), .overflow(overflow)
  );

  la_fifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_acc(wr_acc), .wr_data(wr_data),
    .pop_acc(pop_acc),
    .peek_off(peek_off), .peek_data(peek_data)
  );

  // R2
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pop) |=> $stable(count));

endmodule

// File: tb/sim_la_fifo.sv
`timescale 1ns/100ps
module sim_la_fifo;

  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int AW    = 2;
  localparam int CW    = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          use_prod = 1'b0;
  logic          run = 1'b0;
  logic          b_wr = 1'b0;
  logic [DW-1:0] b_data = '0;
  logic          pop = 1'b0;
  logic [AW-1:0] peek_off = '0;

  logic          p_wr;
  logic [DW-1:0] p_data;
  logic          f_wr;
  logic [DW-1:0] f_data;
  logic          full, almost_full, empty, overflow;
  logic [CW-1:0] count;
  logic [DW-1:0] peek_data;

  assign f_wr   = use_prod ? p_wr   : b_wr;
  assign f_data = use_prod ? p_data : b_data;

  la_seq_producer #(.DW(DW)) u_prod (
    .clk(clk), .rst_n(rst_n), .run(run), .full(full),
    .almost_full(almost_full), .wr_en(p_wr), .wr_data(p_data)
  );

  la_fifo #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(f_wr), .wr_data(f_data),
    .full(full), .almost_full(almost_full), .empty(empty), .count(count),
    .overflow(overflow), .pop(pop), .peek_off(peek_off), .peek_data(peek_data)
  );

  int checks = 0;
  int errors = 0;
  int rot = 0;
  int next_in = 0;
  int next_out = 0;
  bit m_ovf = 1'b0;
  logic [DW-1:0] q[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare outputs with the model; called mid-cycle (after a negedge)
  task automatic compare_all();
    int n;
    n = q.size();
    chk("R2", "count", int'(count), n);
    chk("R4", "full", int'(full), int'(n == DEPTH));
    chk("R5", "almost_full", int'(almost_full), int'(n >= DEPTH - 1));
    chk("R7", "empty", int'(empty), int'(n == 0));
    chk("R8", "overflow", int'(overflow), int'(m_ovf));
    if (n > 0) begin
      int off;
      off = rot % n;
      rot++;
      peek_off = AW'(off);
      #0.2;
      chk("R9", "peek rotating", int'(peek_data), int'(q[off]));
    end
  endtask

  task automatic peek_all();
    for (int k = 0; k < q.size(); k++) begin
      peek_off = AW'(k);
      #0.1;
      chk("R9", "peek sweep", int'(peek_data), int'(q[k]));
    end
  endtask

  // one clock cycle: entered and left just after a negedge
  task automatic cycle(bit wr, logic [DW-1:0] d, bit pp);
    bit ew, wacc, pacc;
    logic [DW-1:0] ed;
    compare_all();
    b_wr = wr; b_data = d; pop = pp;
    #0.2;
    ew = f_wr; ed = f_data;
    wacc = ew && (q.size() < DEPTH);
    pacc = pp && (q.size() > 0);
    if (ew && q.size() == DEPTH) begin
      m_ovf = 1'b1;
      if (use_prod) chk("R6", "producer wrote while full", 1, 0);
    end
    if (use_prod && ew) begin
      chk("R6", "producer sequence", int'(ed), next_in % 256);
      next_in++;
    end
    if (pacc) begin
      logic [DW-1:0] h;
      h = q.pop_front();
      if (use_prod) begin
        chk("R10", "order out", int'(h), next_out % 256);
        next_out++;
      end
    end
    if (wacc) q.push_back(ed);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; b_wr = 1'b0; pop = 1'b0; run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "empty in reset", int'(empty), 1);
    rst_n = 1'b1;
    q.delete(); m_ovf = 1'b0; next_in = 0; next_out = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "empty after reset", int'(empty), 1);
    chk("R1", "full after reset", int'(full), 0);
    chk("R1", "almost_full after reset", int'(almost_full), 0);
    chk("R1", "overflow after reset", int'(overflow), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // Directed fill, overwrite attempt at full, then drain (R4 R5 R8 R9)
    use_prod = 1'b0;
    for (int i = 0; i < DEPTH; i++) cycle(1'b1, DW'(8'hA0 + i), 1'b0);
    chk("R4", "full after fill", int'(full), 1);
    peek_all();
    cycle(1'b1, 8'h55, 1'b0);
    chk("R8", "count kept on write at full", int'(count), DEPTH);
    chk("R8", "overflow raised", int'(overflow), 1);
    peek_all();
    // write and pop together at full: pop taken, write dropped
    cycle(1'b1, 8'h66, 1'b1);
    chk("R4", "full clears on pop", int'(full), 0);
    chk("R2", "count after pop at full", int'(count), DEPTH - 1);
    for (int i = 0; i < DEPTH + 2; i++) cycle(1'b0, '0, 1'b1);
    chk("R7", "pop while empty keeps zero", int'(count), 0);
    chk("R8", "overflow sticky", int'(overflow), 1);
    cycle(1'b1, 8'h11, 1'b1);
    chk("R7", "write with pop on empty", int'(count), 1);
    peek_all();
    do_reset();

    // Near-exhaustive direct sweep over write/pop pairs at every level
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int pat = 0; pat < 4; pat++) begin
        while (q.size() < lvl) cycle(1'b1, DW'(q.size() * 17 + lvl), 1'b0);
        while (q.size() > lvl) cycle(1'b0, '0, 1'b1);
        cycle(pat[0], DW'(pat * 3 + lvl), pat[1]);
        peek_all();
      end
    end
    do_reset();

    // Registered producer, no pops: fills to exactly DEPTH (R3 R6)
    use_prod = 1'b1;
    run = 1'b1;
    for (int i = 0; i < 20; i++) cycle(1'b0, '0, 1'b0);
    chk("R3", "producer fill level", int'(count), DEPTH);
    chk("R6", "no overflow from producer", int'(overflow), 0);
    peek_all();

    // Producer with random pops, ordering under many patterns (R10)
    for (int i = 0; i < 4000; i++) begin
      bit pp;
      int mode;
      mode = (i / 500) % 4;
      case (mode)
        0: pp = 1'b1;
        1: pp = ($urandom_range(0, 3) == 0);
        2: pp = ($urandom_range(0, 1) == 0);
        default: pp = ($urandom_range(0, 7) != 0);
      endcase
      cycle(1'b0, '0, pp);
    end
    chk("R10", "items delivered", int'(next_out > 1000), 1);
    chk("R6", "no overflow in stream", int'(overflow), 0);
    run = 1'b0;
    for (int i = 0; i < 10; i++) cycle(1'b0, '0, 1'b1);
    chk("R10", "drained all", next_out, next_in);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule